// File: doc/BRIEF.md
# Full-Duplex Serial Port with Byte CPU Interface

This block is a full-duplex asynchronous serial port. On the transmit side, a byte written by the CPU becomes a serial frame on `txd`. On the receive side, a frame arriving on `rxd` is rebuilt into a byte. That byte is held for the CPU together with status flags. Three plain configuration inputs apply to both directions. They select the data width (full `DATA_W` bits or one bit fewer), switch the parity bit on or off, and choose odd or even parity.

The CPU side uses active-low strobes. A write is a cycle in which `wr_sel_n` and `wr_en_n` are both low. A read is a cycle in which `rd_sel_n` and `rd_en_n` are both low. The receive path has a single holding register.

- A byte that finishes while the previous one is still unread is discarded, and the overflow flag is raised.
- A write made while the transmitter is busy is dropped. There is no queue, so the CPU must wait for `tx_ready` before writing; that wait is the only back-pressure on the transmit side.

Bit timing comes from a clock divider. The divider produces a 16x sampling tick, so one bit lasts `16*SAMPLE_DIV` clocks. The serial input is synchronised through two flops. A start bit is confirmed at its mid-point before the receiver commits to a frame.

Top module: `duplex_uart`

## Requirements
- R1: After a synchronous reset, `txd` is high, `tx_ready` is high, and `rx_ready`, `rx_parity_err` and `rx_overrun` are low.
- R2: A transmitted frame follows this sequence:
  - one low start bit;
  - the data bits, least-significant first (`DATA_W` bits when `cfg_wide`=1, `DATA_W-1` bits when `cfg_wide`=0; in the narrow case the top bit of the written byte is not sent);
  - one high stop bit.
  Each bit lasts 16*`SAMPLE_DIV` clocks, and the line idles high.
- R3: When `cfg_par_en`=1, a parity bit follows the last data bit. With `cfg_par_odd`=1, the data bits plus the parity bit hold an odd number of ones; with `cfg_par_odd`=0, an even number.
- R4: A write accepted while `tx_ready` is high starts a frame. `tx_ready` goes low on the next cycle and returns high exactly 16*`SAMPLE_DIV` clocks × frame length after the write. A write made while `tx_ready` is low is ignored: it alters neither the frame in flight nor anything after it.
- R5: A write needs `wr_sel_n` and `wr_en_n` low in the same cycle. Either strobe alone starts nothing.
- R6: A received frame sets `rx_ready` and presents the byte on `rd_data`. In narrow mode, bit `DATA_W-1` of `rd_data` reads 0.
- R7: If the received parity bit disagrees with the configured parity, `rx_parity_err` is set with that byte. It stays set until the byte is read.
- R8: A read (`rd_sel_n` and `rd_en_n` both low) clears `rx_ready`. Either strobe alone leaves `rx_ready` set.
- R9: The first unread byte alone never sets `rx_overrun`. A second frame completing while `rx_ready` is set raises `rx_overrun`, keeps the first byte on `rd_data`, and discards the second.
- R10: A low pulse on `rxd` shorter than half a bit is rejected and produces no received byte.
- R11: A read in the same cycle that a new frame completes consumes the old byte. The new byte is loaded, `rx_ready` stays high, and `rx_overrun` stays low.
- R12: The read that consumes a byte also clears `rx_overrun` and `rx_parity_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wide | input | 1 | 1: `DATA_W` data bits; 0: one fewer |
| cfg_par_en | input | 1 | 1: append parity bit |
| cfg_par_odd | input | 1 | 1: odd parity; 0: even parity |
| wr_sel_n | input | 1 | Write select, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Byte captured by a write |
| rd_sel_n | input | 1 | Read select, active low |
| rd_en_n | input | 1 | Read output enable, active low |
| rd_data | output | DATA_W | Held received byte |
| tx_ready | output | 1 | Transmitter can accept a write |
| rx_ready | output | 1 | Unread received byte held |
| rx_parity_err | output | 1 | Held byte arrived with bad parity |
| rx_overrun | output | 1 | A byte was lost while one was held |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The CPU read and the completion of an incoming frame can land on the same clock edge. When they do, the holding register must both release the old byte and take the new one, and it must not report an overflow. The bench drives `rxd` itself, so it knows the edge at which the stop bit is sampled, and it lowers both read strobes for exactly that edge. It then expects `rx_ready` high, the second byte on `rd_data`, and `rx_overrun` low. The same frame sent without the read must instead raise the overflow flag and keep the older byte.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // parity bit value for a data word: even when odd_sel=0, odd when 1
  function automatic logic parity_of(input logic [15:0] word, input logic odd_sel);
    return (^word) ^ odd_sel;
  endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              wide,
  input  logic              pen,
  input  logic              odd,
  output logic              busy,
  output logic              txd
);
  import uart_pkg::*;

  localparam int FW = DATA_W + 2;
  localparam int LW = $clog2(FW + 1);
  localparam int SW = $clog2(OSR);
  localparam logic [SW-1:0] S_LAST = SW'(OSR - 1);

  logic [FW-1:0] frame, asm_bits;
  logic [LW-1:0] left, asm_len;
  logic [SW-1:0] scnt;
  logic [DATA_W-1:0] used;
  logic [15:0] used_ext;

  // assemble the bits that follow the start bit
  always_comb begin
    used = wide ? din : {1'b0, din[DATA_W-2:0]};
    used_ext = 16'(used);
    asm_bits = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (wide || (i < DATA_W - 1)) asm_bits[i] = din[i];
    end
    if (pen) begin
      if (wide) asm_bits[DATA_W] = parity_of(used_ext, odd);
      else asm_bits[DATA_W-1] = parity_of(used_ext, odd);
    end
    asm_len = LW'((wide ? DATA_W : DATA_W - 1) + (pen ? 1 : 0) + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      frame <= '1;
      left  <= '0;
      scnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        frame <= asm_bits;
        left  <= asm_len;
        scnt  <= '0;
      end
    end else if (tick) begin
      if (scnt == S_LAST) begin
        scnt <= '0;
        if (left == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd   <= frame[0];
          frame <= {1'b1, frame[FW-1:1]};
          left  <= left - 1'b1;
        end
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxs,
  input  logic              wide,
  input  logic              pen,
  input  logic              odd,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              bad_par
);
  import uart_pkg::*;

  localparam int SW = $clog2(OSR);
  localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(OSR - 1);
  localparam logic [SW-1:0] S_MID  = SW'(OSR / 2 - 1);

  rx_state_e state;
  logic [SW-1:0] scnt;
  logic [IW-1:0] idx;
  logic c_wide, c_pen, c_odd;
  logic sample;

  assign sample = tick && (scnt == S_LAST);
  assign idle   = (state == RX_IDLE);
  assign done   = (state == RX_STOP) && sample;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      scnt    <= '0;
      idx     <= '0;
      dout    <= '0;
      bad_par <= 1'b0;
      c_wide  <= 1'b1;
      c_pen   <= 1'b0;
      c_odd   <= 1'b0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          scnt <= '0;
          if (!rxs) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (scnt == S_MID) begin
            scnt <= '0;
            if (!rxs) begin
              state   <= RX_DATA;
              idx     <= '0;
              dout    <= '0;
              bad_par <= 1'b0;
              c_wide  <= wide;
              c_pen   <= pen;
              c_odd   <= odd;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (sample) begin
            scnt <= '0;
            dout[idx] <= rxs;
            if (idx == IW'(c_wide ? DATA_W - 1 : DATA_W - 2))
              state <= c_pen ? RX_PAR : RX_STOP;
            else
              idx <= idx + 1'b1;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        RX_PAR: if (tick) begin
          if (sample) begin
            scnt    <= '0;
            bad_par <= (rxs != parity_of(16'(dout), c_odd));
            state   <= RX_STOP;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (sample) begin
            scnt  <= '0;
            state <= RX_IDLE;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/duplex_uart.sv
module duplex_uart #(
  parameter int DATA_W     = 8,
  parameter int SAMPLE_DIV = 2,
  parameter int OSR        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wide,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              wr_sel_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel_n,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              rx_parity_err,
  output logic              rx_overrun,
  output logic              txd,
  input  logic              rxd
);
  logic tx_busy, tx_tick, rx_tick, rx_idle, rx_done, rx_bad;
  logic wr_fire, rd_fire;
  logic [DATA_W-1:0] rx_word;
  logic [SYNC_DEPTH-1:0] sync_q;

  assign wr_fire  = !wr_sel_n && !wr_en_n && !tx_busy;
  assign rd_fire  = !rd_sel_n && !rd_en_n;
  assign tx_ready = !tx_busy;

  // input synchroniser chain
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else sync_q <= {sync_q[SYNC_DEPTH-2:0], rxd};
  end

  uart_tick_gen #(.DIV(SAMPLE_DIV)) u_tx_tick (
    .clk(clk), .rst(rst), .clr(!tx_busy), .tick(tx_tick));

  uart_tick_gen #(.DIV(SAMPLE_DIV)) u_rx_tick (
    .clk(clk), .rst(rst), .clr(rx_idle), .tick(rx_tick));

  uart_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .start(wr_fire), .din(wr_data),
    .wide(cfg_wide), .pen(cfg_par_en), .odd(cfg_par_odd),
    .busy(tx_busy), .txd(txd));

  uart_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .rxs(sync_q[SYNC_DEPTH-1]),
    .wide(cfg_wide), .pen(cfg_par_en), .odd(cfg_par_odd),
    .idle(rx_idle), .done(rx_done), .dout(rx_word), .bad_par(rx_bad));

  // single-entry holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data       <= '0;
      rx_ready      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_overrun    <= 1'b0;
    end else if (rx_done) begin
      if (rx_ready && !rd_fire) begin
        rx_overrun <= 1'b1;
      end else begin
        rd_data       <= rx_word;
        rx_parity_err <= rx_bad;
        rx_ready      <= 1'b1;
        rx_overrun    <= 1'b0;
      end
    end else if (rd_fire) begin
      rx_ready      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_overrun    <= 1'b0;
    end
  end
endmodule

// File: rtl/duplex_uart_chk.sv
module duplex_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_sel_n,
  input logic              wr_en_n,
  input logic              rd_sel_n,
  input logic              rd_en_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic              rx_parity_err,
  input logic              rx_overrun,
  input logic              txd
);
  // R2
  tx_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd);

  // R4
  tx_ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> $past(!wr_sel_n && !wr_en_n));

  // R5
  write_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && (wr_sel_n || wr_en_n)) |=> tx_ready);

  // R7
  perr_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    rx_parity_err |-> rx_ready);

  // R9
  keep_old_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overrun) |-> ($past(rx_ready) && rx_ready && $stable(rd_data)));

  // R12
  read_clears_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_sel_n && !rd_en_n) |=> !rx_overrun);
endmodule

bind duplex_uart duplex_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_sel_n(wr_sel_n), .wr_en_n(wr_en_n),
  .rd_sel_n(rd_sel_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
  .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_parity_err(rx_parity_err),
  .rx_overrun(rx_overrun), .txd(txd));

// File: tb/duplex_uart_bench.sv
`timescale 1ns/1ps
module duplex_uart_bench;
  localparam int DW  = 8;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wide = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic wr_sel_n = 1'b1, wr_en_n = 1'b1, rd_sel_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic tx_ready, rx_ready, rx_parity_err, rx_overrun, txd;
  logic rxd = 1'b1;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  duplex_uart #(.DATA_W(DW), .SAMPLE_DIV(DIV)) u_duplex_uart (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .wr_sel_n(wr_sel_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .rd_sel_n(rd_sel_n), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .rx_parity_err(rx_parity_err), .rx_overrun(rx_overrun), .txd(txd),
    .rxd(rxd));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bits after the start bit: data, optional parity, stop
  function automatic int frame_len(input bit wide, input bit pen);
    return (wide ? DW : DW - 1) + (pen ? 1 : 0) + 1;
  endfunction

  function automatic logic [15:0] frame_bits(input logic [DW-1:0] d, input bit wide,
                                             input bit pen, input bit odd, input bit flip);
    logic [15:0] f;
    int nb, ones;
    nb = wide ? DW : DW - 1;
    f = '1;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      f[i] = d[i];
      if (d[i]) ones++;
    end
    if (pen) f[nb] = ((ones % 2 == 1) != odd) ^ flip;
    return f;
  endfunction

  task automatic set_cfg(input bit w, input bit p, input bit o);
    @(negedge clk);
    cfg_wide = w; cfg_par_en = p; cfg_par_odd = o;
  endtask

  task automatic cpu_read();
    @(negedge clk);
    rd_sel_n = 1'b0; rd_en_n = 1'b0;
    @(negedge clk);
    rd_sel_n = 1'b1; rd_en_n = 1'b1;
  endtask

  // write a byte and watch the whole frame on txd
  task automatic tx_frame(input logic [DW-1:0] d, input bit inject);
    logic [15:0] exp_f, got_f;
    int n, wait_n;
    n = frame_len(cfg_wide, cfg_par_en) + 1;
    exp_f = {frame_bits(d, cfg_wide, cfg_par_en, cfg_par_odd, 1'b0)[14:0], 1'b0};
    got_f = '1;
    @(negedge clk);
    wr_data = d; wr_sel_n = 1'b0; wr_en_n = 1'b0;
    @(negedge clk);
    wr_sel_n = 1'b1; wr_en_n = 1'b1;
    repeat (BIT / 2) @(negedge clk);
    got_f[0] = txd;
    check("R4 busy during frame", 32'(tx_ready), 32'd0);
    for (int m = 1; m < n; m++) begin
      wait_n = BIT;
      if (inject && m == 1) begin
        wr_data = ~d; wr_sel_n = 1'b0; wr_en_n = 1'b0;
        @(negedge clk);
        wr_sel_n = 1'b1; wr_en_n = 1'b1;
        wait_n = BIT - 1;
      end
      repeat (wait_n) @(negedge clk);
      got_f[m] = txd;
    end
    check("R2/R3 frame bits", 32'(got_f), 32'(exp_f));
    repeat (BIT / 2 - 1) @(negedge clk);
    check("R4 still busy before end", 32'(tx_ready), 32'd0);
    @(negedge clk);
    check("R4 ready after frame", 32'(tx_ready), 32'd1);
    if (inject) begin
      got_f = '0;
      for (int k = 0; k < 2 * BIT; k++) begin
        @(negedge clk);
        if (!txd || !tx_ready) got_f[0] = 1'b1;
      end
      check("R4 busy write ignored", 32'(got_f[0]), 32'd0);
    end
  endtask

  // drive a frame on rxd; optionally read exactly when the stop bit is sampled
  task automatic rx_frame(input logic [DW-1:0] d, input bit flip, input bit rd_at_stop);
    logic [15:0] f;
    int n;
    n = frame_len(cfg_wide, cfg_par_en);
    f = frame_bits(d, cfg_wide, cfg_par_en, cfg_par_odd, flip);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int m = 0; m < n; m++) begin
      rxd = f[m];
      for (int j = 0; j < BIT; j++) begin
        if (rd_at_stop && m == n - 1 && j == 18) begin rd_sel_n = 1'b0; rd_en_n = 1'b0; end
        if (rd_at_stop && m == n - 1 && j == 19) begin rd_sel_n = 1'b1; rd_en_n = 1'b1; end
        @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, m7;
    bit w, p, o, fl;
    d = DW'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 txd", 32'(txd), 32'd1);
    check("R1 tx_ready", 32'(tx_ready), 32'd1);
    check("R1 rx flags", {29'd0, rx_ready, rx_parity_err, rx_overrun}, 32'd0);

    // R5 single write strobe
    @(negedge clk); wr_data = 8'h3C; wr_sel_n = 1'b0;
    @(negedge clk); wr_sel_n = 1'b1; wr_en_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 lone strobe no start", {30'd0, tx_ready, txd}, 32'd3);

    // directed transmit corners
    set_cfg(1, 0, 0); tx_frame(8'hA5, 1'b0);
    set_cfg(0, 1, 1); tx_frame(8'hFF, 1'b0);
    set_cfg(1, 1, 0); tx_frame(8'h81, 1'b1);

    // random transmit
    for (int i = 0; i < 20; i++) begin
      w = 1'($urandom); p = 1'($urandom); o = 1'($urandom);
      set_cfg(w, p, o);
      tx_frame(DW'($urandom), 1'b0);
    end

    // random receive, some with corrupted parity
    for (int i = 0; i < 20; i++) begin
      w = 1'($urandom); p = 1'($urandom); o = 1'($urandom);
      fl = p && ($urandom % 3 == 0);
      d = DW'($urandom);
      set_cfg(w, p, o);
      rx_frame(d, fl, 1'b0);
      m7 = w ? d : {1'b0, d[DW-2:0]};
      check("R6 rx_ready set", 32'(rx_ready), 32'd1);
      check("R6 received byte", 32'(rd_data), 32'(m7));
      check("R7 parity flag", 32'(rx_parity_err), 32'(fl));
      cpu_read();
      check("R8 read clears ready", 32'(rx_ready), 32'd0);
      check("R12 read clears parity flag", 32'(rx_parity_err), 32'd0);
    end

    // R8 lone read strobe leaves data pending
    set_cfg(1, 0, 0);
    rx_frame(8'h5A, 1'b0, 1'b0);
    @(negedge clk); rd_en_n = 1'b0;
    @(negedge clk); rd_en_n = 1'b1;
    check("R8 lone strobe keeps ready", 32'(rx_ready), 32'd1);
    cpu_read();

    // R10 short glitch
    @(negedge clk); rxd = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R10 glitch rejected", 32'(rx_ready), 32'd0);

    // R9 overflow keeps the older byte
    set_cfg(1, 1, 0);
    rx_frame(8'hA5, 1'b0, 1'b0);
    check("R9 no overflow after first", 32'(rx_overrun), 32'd0);
    rx_frame(8'h5A, 1'b0, 1'b0);
    check("R9 overflow raised", 32'(rx_overrun), 32'd1);
    check("R9 older byte kept", 32'(rd_data), 32'hA5);
    cpu_read();
    check("R12 read clears overflow", {30'd0, rx_overrun, rx_ready}, 32'd0);

    // R11 read coincident with frame completion
    rx_frame(8'h11, 1'b0, 1'b0);
    rx_frame(8'h22, 1'b1, 1'b1);
    check("R11 ready after coincident read", 32'(rx_ready), 32'd1);
    check("R11 new byte loaded", 32'(rd_data), 32'h22);
    check("R11 no overflow", 32'(rx_overrun), 32'd0);
    check("R11 new parity flag", 32'(rx_parity_err), 32'd1);
    cpu_read();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule